// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block makes the bit timing for a serial transceiver. A 12-bit reloadable down-counter divides the system clock into a prescale pulse that occurs once every `divisor + 1` cycles. In asynchronous operation the prescale pulse is the receiver oversampling tick. A second counter divides it by 16 to make the transmit bit tick. When double speed is selected, that counter divides by 8 instead. In synchronous master operation the prescale pulse toggles a serial clock output. Transmit ticks line up with its falling edges and receive ticks with its rising edges.

In synchronous slave operation the divider output is not used. An external serial clock pin goes through one synchronizing register and then an edge detector. A rising pin edge gives a one-cycle receive strobe and a falling edge gives a one-cycle transmit strobe. Each strobe appears two system clock edges after the pin change.

The mode and double-speed inputs are meant to be quasi-static. Software updates `divisor` and pulses `divisorWr` in the same cycle.

Top module: `bitclk_gen`

## Requirements
- R1: Mode code 2'b00 selects asynchronous operation. With double speed off, `rxTick` pulses every `divisor+1` cycles and `txTick` pulses every `16*(divisor+1)` cycles.
- R2: In asynchronous operation with `dblSpeed` high, `txTick` pulses every `8*(divisor+1)` cycles and `rxTick` keeps its `divisor+1` spacing, giving 8 oversample ticks per bit.
- R3: Mode code 2'b01 selects synchronous master operation. Both `txTick` and `rxTick` pulse every `2*(divisor+1)` cycles. Each `txTick` arrives with a falling edge of `sclkOut` and each `rxTick` with a rising edge.
- R4: `dblSpeed` has no effect on tick spacing in synchronous master operation.
- R5: The full divisor range 0 to 4095 works. Divisor 0 makes `rxTick` high every cycle in asynchronous operation, and 4095 gives a master tick spacing of 8192 cycles.
- R6: A `divisorWr` pulse reloads the counter at once. The first `rxTick` after the write comes `divisor+1` clock edges after the edge that captured the write, whatever count was in progress.
- R7: Mode codes 2'b10 and 2'b11 select synchronous slave operation. A rising edge on `extClkIn` gives a single-cycle `rxTick`, and a falling edge gives a single-cycle `txTick`. Each strobe is visible after the second rising clock edge following the pin change.
- R8: `sclkOut` stays low in asynchronous and slave operation.
- R9: While reset is active, `txTick`, `rxTick` and `sclkOut` are low.
- R10: In asynchronous operation every `txTick` coincides with an `rxTick`. In synchronous operation the two never fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 12 | Divider setting, period is divisor+1 cycles |
| divisorWr | input | 1 | One-cycle pulse: new divisor written, reload counter |
| mode | input | 2 | 00 async, 01 sync master, 1x sync slave |
| dblSpeed | input | 1 | Halve async bit period (async only) |
| extClkIn | input | 1 | External serial clock for slave operation |
| txTick | output | 1 | Transmit bit tick / strobe |
| rxTick | output | 1 | Receive oversample tick / strobe |
| sclkOut | output | 1 | Serial clock output in master operation |

## Verification
The bench measures tick spacing at both ends of the divisor range, because an off-by-one in the reload would make every period `divisor` or `divisor+2` cycles long. At divisor 0 the same error would stall the divider or double its period. It repeats the master measurement with double speed on and off, which catches a design that lets the doubling leak into synchronous operation. It writes a small divisor while a 4096-cycle count is running, and a design that waits for the old count to expire would miss the four-cycle deadline. It times the slave strobes edge by edge: an extra or missing synchronizer stage moves the strobe one cycle, and a level detector instead of an edge detector would hold the strobe high for several cycles.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  localparam int POST_W = 4;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_SLAVE  = 2'b10,
    MODE_SLAVE2 = 2'b11
  } clk_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              reload;
    logic              preTick;
    logic              asyncMode;
    logic              master;
    logic              slave;
    logic [POST_W-1:0] postLast;
  } ctl_t;

endpackage

// File: rtl/bitclk_ctrl.sv
module bitclk_ctrl
  import bitclk_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             divisorWr,
  input  logic [1:0]       mode,
  input  logic             dblSpeed,
  output ctl_t             ctl
);

  localparam logic [POST_W-1:0] LAST_NORMAL = POST_W'(15);
  localparam logic [POST_W-1:0] LAST_DOUBLE = POST_W'(7);

  logic [DIV_W-1:0] cnt;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (divisorWr) cnt <= divisor;
    else if (cntZero)   cnt <= divisor;
    else                cnt <= cnt - 1'b1;
  end

  always_comb begin
    ctl.reload    = divisorWr;
    ctl.preTick   = cntZero && !divisorWr;
    ctl.asyncMode = (mode == MODE_ASYNC);
    ctl.master    = (mode == MODE_MASTER);
    ctl.slave     = mode[1];
    ctl.postLast  = (ctl.asyncMode && dblSpeed) ? LAST_DOUBLE : LAST_NORMAL;
  end

  // R6
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divisorWr && divisor != '0) |=> !ctl.preTick);

endmodule

// File: rtl/bitclk_dp.sv
module bitclk_dp
  import bitclk_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic extClkIn,
  output logic txTick,
  output logic rxTick,
  output logic sclkOut
);

  logic [POST_W-1:0] post;
  logic              postWrap;
  logic              syncReg;
  logic              prevReg;
  logic              extRise;
  logic              extFall;
  logic              sclkQ;
  logic              txNext;
  logic              rxNext;

  assign postWrap = (post >= ctl.postLast);

  // post divider: 16 or 8 prescale pulses per bit
  always_ff @(posedge clk) begin
    if (!rstN || ctl.reload) post <= '0;
    else if (ctl.preTick)    post <= postWrap ? '0 : post + 1'b1;
  end

  // external clock: synchronizer then edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= 1'b0;
      prevReg <= 1'b0;
    end else begin
      syncReg <= extClkIn;
      prevReg <= syncReg;
    end
  end

  assign extRise = syncReg && !prevReg;
  assign extFall = !syncReg && prevReg;

  // master serial clock
  always_ff @(posedge clk) begin
    if (!rstN || ctl.reload || !ctl.master) sclkQ <= 1'b0;
    else if (ctl.preTick)                   sclkQ <= !sclkQ;
  end

  always_comb begin
    if (ctl.slave) begin
      txNext = extFall;
      rxNext = extRise;
    end else if (ctl.master) begin
      txNext = ctl.preTick && sclkQ;
      rxNext = ctl.preTick && !sclkQ;
    end else begin
      txNext = ctl.preTick && postWrap;
      rxNext = ctl.preTick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txTick <= 1'b0;
      rxTick <= 1'b0;
    end else begin
      txTick <= txNext;
      rxTick <= rxNext;
    end
  end

  assign sclkOut = sclkQ;

  // R10
  async_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.asyncMode) && txTick) |-> rxTick);

  // R10
  sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.asyncMode) |-> !(txTick && rxTick));

  // R7
  slave_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slave && $past(ctl.slave) && rxTick) |=> !rxTick);

  // R3
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.master && !ctl.preTick && !ctl.reload) |=> $stable(sclkOut));

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             divisorWr,
  input  logic [1:0]       mode,
  input  logic             dblSpeed,
  input  logic             extClkIn,
  output logic             txTick,
  output logic             rxTick,
  output logic             sclkOut
);

  ctl_t ctl;

  bitclk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .divisor   (divisor),
    .divisorWr (divisorWr),
    .mode      (mode),
    .dblSpeed  (dblSpeed),
    .ctl       (ctl)
  );

  bitclk_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .extClkIn (extClkIn),
    .txTick   (txTick),
    .rxTick   (rxTick),
    .sclkOut  (sclkOut)
  );

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!txTick && !rxTick && !sclkOut));

endmodule

// File: tb/bitclk_gen_bench.sv
module bitclk_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] divisor = '0;
  logic        divisorWr = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        dblSpeed = 1'b0;
  logic        extClkIn = 1'b0;
  logic        txTick, rxTick, sclkOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bitclk_gen u_bitclk_gen (
    .clk(clk), .rstN(rstN), .divisor(divisor), .divisorWr(divisorWr),
    .mode(mode), .dblSpeed(dblSpeed), .extClkIn(extClkIn),
    .txTick(txTick), .rxTick(rxTick), .sclkOut(sclkOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? txTick : rxTick;
  endfunction

  task automatic setup(input logic [1:0] m, input logic dbl, input int d);
    @(negedge clk);
    mode = m; dblSpeed = dbl; divisor = 12'(d); divisorWr = 1'b1;
    @(negedge clk);
    divisorWr = 1'b0;
  endtask

  // spacing between two consecutive ticks on the selected output
  task automatic gap(input int sel, input int exp, input string req);
    int n = 0;
    int g = 0;
    while (!pick(sel) && g < 70000) begin @(negedge clk); g++; end
    do begin @(negedge clk); n++; end while (!pick(sel) && n < 70000);
    check(n == exp, req, n, exp);
  endtask

  task automatic testReset();
    check(!txTick && !rxTick && !sclkOut, "R9", {txTick, rxTick, sclkOut}, 0);
  endtask

  task automatic testAsyncNormal();
    setup(2'b00, 1'b0, 5);
    gap(1, 6, "R1 rx");
    gap(0, 96, "R1 tx");
    check(rxTick == 1'b1, "R10 async align", rxTick, 1);
  endtask

  task automatic testAsyncDouble();
    setup(2'b00, 1'b1, 5);
    gap(0, 48, "R2 tx");
    gap(1, 6, "R2 rx");
  endtask

  task automatic testDivZero();
    setup(2'b00, 1'b0, 0);
    gap(1, 1, "R5 div0 rx");
    gap(0, 16, "R5 div0 tx");
  endtask

  task automatic testMaster();
    setup(2'b01, 1'b0, 2);
    gap(0, 6, "R3 tx");
    check(!sclkOut && !rxTick, "R3 tx on falling", {sclkOut, rxTick}, 0);
    gap(1, 6, "R3 rx");
    check(sclkOut && !txTick, "R3 rx on rising", {sclkOut, txTick}, 2);
    setup(2'b01, 1'b1, 2);
    gap(0, 6, "R4 dbl ignored tx");
    gap(1, 6, "R4 dbl ignored rx");
  endtask

  task automatic testMasterMax();
    setup(2'b01, 1'b0, 4095);
    gap(0, 8192, "R5 div4095 master tx");
    setup(2'b00, 1'b0, 4095);
    gap(1, 4096, "R5 div4095 async rx");
  endtask

  task automatic testReload();
    int n = 0;
    setup(2'b00, 1'b0, 4095);
    repeat (100) @(negedge clk);
    divisor = 12'd3; divisorWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    divisorWr = 1'b0;
    while (!rxTick && n < 5000) begin @(posedge clk); n++; @(negedge clk); end
    check(n == 4, "R6 reload latency", n, 4);
  endtask

  task automatic testSclkQuiet();
    int hi = 0;
    setup(2'b00, 1'b0, 1);
    repeat (40) begin @(negedge clk); if (sclkOut) hi++; end
    setup(2'b10, 1'b0, 1);
    repeat (40) begin @(negedge clk); if (sclkOut) hi++; end
    check(hi == 0, "R8 sclk low", hi, 0);
  endtask

  task automatic testSlave(input logic [1:0] m);
    setup(m, 1'b1, 0);
    extClkIn = 1'b0;
    repeat (4) @(negedge clk);
    extClkIn = 1'b1;
    @(negedge clk);
    check(!rxTick, "R7 rise not early", rxTick, 0);
    @(negedge clk);
    check(rxTick && !txTick, "R7 rise strobe", {rxTick, txTick}, 2);
    @(negedge clk);
    check(!rxTick, "R7 rise single", rxTick, 0);
    repeat (3) @(negedge clk);
    extClkIn = 1'b0;
    @(negedge clk);
    check(!txTick, "R7 fall not early", txTick, 0);
    @(negedge clk);
    check(txTick && !rxTick, "R7 fall strobe", {txTick, rxTick}, 2);
    @(negedge clk);
    check(!txTick, "R7 fall single", txTick, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAsyncNormal();
    testAsyncDouble();
    testDivZero();
    testMaster();
    testMasterMax();
    testReload();
    testSclkQuiet();
    testSlave(2'b10);
    testSlave(2'b11);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule